// File: doc/BRIEF.md
# Boundary Scan Data Register

This block is the boundary scan data register of a test access port. It places one scan cell next to every input pad, every output pad and every bidirectional pad. It also gives every output and every bidirectional pad its own direction-control cell. An external TAP state machine and instruction decoder drive the block. They supply a register-select qualifier, the capture, shift and update strobes, and two decoded instruction flags: one for external test and one for sample/preload. All strobes and flags are sampled on the rising edge of the test clock.

The block has two stages. The first is a serial stage that captures pad state and shifts between the serial input and the serial output. The second is a parallel hold stage that is loaded from the serial stage on update. While the external-test flag is high, the hold stage drives the output pads, the bidirectional pads and their enables. While the flag is low, the core signals pass straight through to the pads. What a capture loads depends on the instruction flag: sample/preload records every pad, while external test records only what the pads receive.

The cell counts are parameters: `NI` input pads, `NO` output pads and `NB` bidirectional pads, each at least 1. The default build is 297 cells (99, 51 and 48).

Top module: `bscan_chain`

## Requirements
- R1: The chain has L = NI + 2*NO + 2*NB cells. Cell i (0 ≤ i < NI) belongs to input pad i. Output pad k uses cell NI+2k for data and cell NI+2k+1 for its enable. Bidirectional pad k uses cell NI+2*NO+2k for data and cell NI+2*NO+2k+1 for its enable.
- R2: On a clock edge with `sel` and `shift_dr` high and `capture_dr` low, every serial-stage cell takes the value of the next-higher cell. Cell L-1 takes `tdi`. `tdo` always shows serial cell 0.
- R3: On a clock edge with `sel` and `capture_dr` high, `sample` high and `extest` low, capture loads the following:
  - input cells from `in_pad`;
  - output data and enable cells from `out_pad` and `out_pad_en`;
  - bidirectional enable cells from `bidi_pad_en`;
  - each bidirectional data cell from `bidi_pad_out` when its `bidi_pad_en` bit is 1, and from `bidi_pad_in` when it is 0.
- R4: On a clock edge with `sel`, `capture_dr` and `extest` high, capture loads input cells from `in_pad` and bidirectional data cells from `bidi_pad_in`, whatever the enables are. Output data, output enable and bidirectional enable cells keep their contents. `extest` takes priority over `sample`.
- R5: A clock edge with `sel` low changes neither stage. A capture with both `extest` and `sample` low leaves the serial stage unchanged.
- R6: On a clock edge with `sel` and `update_dr` high, the hold stage loads the serial stage's pre-edge contents.
- R7: While `extest` is high, `out_pad[k]` equals hold cell NI+2k and `out_pad_en[k]` equals hold cell NI+2k+1.
- R8: While `extest` is high, `bidi_pad_out[k]` equals hold cell NI+2*NO+2k and `bidi_pad_en[k]` equals hold cell NI+2*NO+2k+1.
- R9: While `extest` is low, `out_pad`, `out_pad_en`, `bidi_pad_out` and `bidi_pad_en` equal `core_out`, `core_out_en`, `core_bidi` and `core_bidi_en`. The hold stage has no effect on them.
- R10: `trst_n` low clears both stages at once, without waiting for a clock. After reset, all enables driven under `extest` are 0, so the bidirectional pads act as inputs, and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sel | input | 1 | This register is selected by the current instruction |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| extest | input | 1 | Decoded external-test instruction |
| sample | input | 1 | Decoded sample/preload instruction |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| in_pad | input | NI | Input pad values |
| core_out | input | NO | Core output data |
| core_out_en | input | NO | Core output enables |
| core_bidi | input | NB | Core bidirectional data |
| core_bidi_en | input | NB | Core bidirectional enables |
| bidi_pad_in | input | NB | Values received at the bidirectional pads |
| out_pad | output | NO | Output pad data |
| out_pad_en | output | NO | Output pad enables |
| bidi_pad_out | output | NB | Bidirectional pad drive data |
| bidi_pad_en | output | NB | Bidirectional pad drive enables |

## Verification
The bench aims at these faults:
- An external-test capture that overwrites output cells or takes bidirectional data from the drive side. Either fault would show up as wrong bits when the chain is shifted out.
- A sample capture that ignores the direction of a bidirectional pad. This would report the received value for a pad that is driving.
- An unselected or flagless strobe that still changes a stage. This would corrupt the next shift-out or move pads that should hold still.
- An off-by-one in the cell layout, or a mux that leaks hold-stage data while `extest` is low. Both would appear at once as pad mismatches against the reference model.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    CAP_KEEP   = 2'd0,
    CAP_SAMPLE = 2'd1,
    CAP_EXTEST = 2'd2
  } cap_mode_e;

  // Cell positions within the chain; shared by capture and pin logic.
  function automatic int out_data_pos(int ni, int k);
    return ni + 2 * k;
  endfunction

  function automatic int out_en_pos(int ni, int k);
    return ni + 2 * k + 1;
  endfunction

  function automatic int bidi_data_pos(int ni, int no, int k);
    return ni + 2 * no + 2 * k;
  endfunction

  function automatic int bidi_en_pos(int ni, int no, int k);
    return ni + 2 * no + 2 * k + 1;
  endfunction

  function automatic int chain_len(int ni, int no, int nb);
    return ni + 2 * no + 2 * nb;
  endfunction

endpackage

// File: rtl/bscan_capture.sv
module bscan_capture
  import bscan_pkg::*;
#(
  parameter int NI = 99,
  parameter int NO = 51,
  parameter int NB = 48,
  localparam int L = chain_len(NI, NO, NB)
) (
  input  cap_mode_e         mode,
  input  logic [L-1:0]      sr_q,
  input  logic [NI-1:0]     in_pad,
  input  logic [NO-1:0]     out_pad,
  input  logic [NO-1:0]     out_pad_en,
  input  logic [NB-1:0]     bidi_pad_out,
  input  logic [NB-1:0]     bidi_pad_en,
  input  logic [NB-1:0]     bidi_pad_in,
  output logic [L-1:0]      cap_vec
);

  logic any_cap;
  logic is_sample;
  assign any_cap   = (mode == CAP_SAMPLE) || (mode == CAP_EXTEST);
  assign is_sample = (mode == CAP_SAMPLE);

  // Input cells: loaded by either capture rule.
  for (genvar i = 0; i < NI; i++) begin : g_in
    assign cap_vec[i] = any_cap ? in_pad[i] : sr_q[i];
  end

  // Output cells: only the sample rule records them.
  for (genvar k = 0; k < NO; k++) begin : g_out
    localparam int DP = out_data_pos(NI, k);
    localparam int EP = out_en_pos(NI, k);
    assign cap_vec[DP] = is_sample ? out_pad[k]    : sr_q[DP];
    assign cap_vec[EP] = is_sample ? out_pad_en[k] : sr_q[EP];
  end

  // Bidirectional cells: direction-aware under sample, input-only under extest.
  for (genvar k = 0; k < NB; k++) begin : g_bidi
    localparam int DP = bidi_data_pos(NI, NO, k);
    localparam int EP = bidi_en_pos(NI, NO, k);
    logic seen;
    assign seen = bidi_pad_en[k] ? bidi_pad_out[k] : bidi_pad_in[k];
    always_comb begin
      unique case (mode)
        CAP_SAMPLE: cap_vec[DP] = seen;
        CAP_EXTEST: cap_vec[DP] = bidi_pad_in[k];
        default:    cap_vec[DP] = sr_q[DP];
      endcase
    end
    assign cap_vec[EP] = is_sample ? bidi_pad_en[k] : sr_q[EP];
  end

endmodule

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage #(
  parameter int L = 297
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [L-1:0] cap_vec,
  input  logic         tdi,
  output logic [L-1:0] sr_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= cap_vec;
    end else if (shift) begin
      sr_q <= {tdi, sr_q[L-1:1]};
    end
  end

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage #(
  parameter int L = 297
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         load,
  input  logic [L-1:0] d,
  output logic [L-1:0] q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
  import bscan_pkg::*;
#(
  parameter int NI = 99,
  parameter int NO = 51,
  parameter int NB = 48,
  localparam int W = 2 * NO + 2 * NB
) (
  input  logic          extest,
  input  logic [W-1:0]  hold,
  input  logic [NO-1:0] core_out,
  input  logic [NO-1:0] core_out_en,
  input  logic [NB-1:0] core_bidi,
  input  logic [NB-1:0] core_bidi_en,
  output logic [NO-1:0] out_pad,
  output logic [NO-1:0] out_pad_en,
  output logic [NB-1:0] bidi_pad_out,
  output logic [NB-1:0] bidi_pad_en
);

  // hold carries only the output and bidirectional cells (chain index minus NI).
  for (genvar k = 0; k < NO; k++) begin : g_out
    localparam int DP = out_data_pos(NI, k) - NI;
    localparam int EP = out_en_pos(NI, k) - NI;
    assign out_pad[k]    = extest ? hold[DP] : core_out[k];
    assign out_pad_en[k] = extest ? hold[EP] : core_out_en[k];
  end

  for (genvar k = 0; k < NB; k++) begin : g_bidi
    localparam int DP = bidi_data_pos(NI, NO, k) - NI;
    localparam int EP = bidi_en_pos(NI, NO, k) - NI;
    assign bidi_pad_out[k] = extest ? hold[DP] : core_bidi[k];
    assign bidi_pad_en[k]  = extest ? hold[EP] : core_bidi_en[k];
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NI = 99,
  parameter int NO = 51,
  parameter int NB = 48
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          sel,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          extest,
  input  logic          sample,
  input  logic          tdi,
  output logic          tdo,
  input  logic [NI-1:0] in_pad,
  input  logic [NO-1:0] core_out,
  input  logic [NO-1:0] core_out_en,
  input  logic [NB-1:0] core_bidi,
  input  logic [NB-1:0] core_bidi_en,
  input  logic [NB-1:0] bidi_pad_in,
  output logic [NO-1:0] out_pad,
  output logic [NO-1:0] out_pad_en,
  output logic [NB-1:0] bidi_pad_out,
  output logic [NB-1:0] bidi_pad_en
);

  localparam int L = chain_len(NI, NO, NB);

  // Named events, visible to the bound checker.
  logic      cap_fire;
  logic      shift_fire;
  logic      upd_fire;
  cap_mode_e cap_mode;
  logic [L-1:0] sr_q;
  logic [L-1:0] ur_q;
  logic [L-1:0] cap_vec;

  assign cap_fire   = sel && capture_dr;
  assign shift_fire = sel && shift_dr && !capture_dr;
  assign upd_fire   = sel && update_dr;

  always_comb begin
    if (extest)      cap_mode = CAP_EXTEST;
    else if (sample) cap_mode = CAP_SAMPLE;
    else             cap_mode = CAP_KEEP;
  end

  bscan_capture #(.NI(NI), .NO(NO), .NB(NB)) u_cap (
    .mode         (cap_mode),
    .sr_q         (sr_q),
    .in_pad       (in_pad),
    .out_pad      (out_pad),
    .out_pad_en   (out_pad_en),
    .bidi_pad_out (bidi_pad_out),
    .bidi_pad_en  (bidi_pad_en),
    .bidi_pad_in  (bidi_pad_in),
    .cap_vec      (cap_vec)
  );

  bscan_shift_stage #(.L(L)) u_shift (
    .tck     (tck),
    .trst_n  (trst_n),
    .load    (cap_fire),
    .shift   (shift_fire),
    .cap_vec (cap_vec),
    .tdi     (tdi),
    .sr_q    (sr_q)
  );

  bscan_update_stage #(.L(L)) u_upd (
    .tck    (tck),
    .trst_n (trst_n),
    .load   (upd_fire),
    .d      (sr_q),
    .q      (ur_q)
  );

  bscan_pin_mux #(.NI(NI), .NO(NO), .NB(NB)) u_mux (
    .extest       (extest),
    .hold         (ur_q[L-1:NI]),
    .core_out     (core_out),
    .core_out_en  (core_out_en),
    .core_bidi    (core_bidi),
    .core_bidi_en (core_bidi_en),
    .out_pad      (out_pad),
    .out_pad_en   (out_pad_en),
    .bidi_pad_out (bidi_pad_out),
    .bidi_pad_en  (bidi_pad_en)
  );

  assign tdo = sr_q[0];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int NI = 99,
  parameter int NO = 51,
  parameter int NB = 48,
  localparam int L = NI + 2 * NO + 2 * NB
) (
  input logic          tck,
  input logic          trst_n,
  input logic          sel,
  input logic          extest,
  input logic          tdo,
  input logic [NO-1:0] core_out,
  input logic [NB-1:0] core_bidi_en,
  input logic [NO-1:0] out_pad,
  input logic [NB-1:0] bidi_pad_en,
  input logic          cap_fire,
  input logic          shift_fire,
  input logic          upd_fire,
  input logic [L-1:0]  sr_q,
  input logic [L-1:0]  ur_q
);

  assert_shift_moves_R2: assert property (@(posedge tck) disable iff (!trst_n)
    shift_fire |=> tdo == $past(sr_q[1]));

  assert_extest_keeps_out_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_fire && extest) |=> sr_q[NI] == $past(sr_q[NI]) && sr_q[NI+1] == $past(sr_q[NI+1]));

  assert_unselected_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(sr_q) && $stable(ur_q));

  assert_update_load_R6: assert property (@(posedge tck) disable iff (!trst_n)
    upd_fire |=> ur_q == $past(sr_q));

  assert_passthru_R9: assert property (@(posedge tck) disable iff (!trst_n)
    !extest |-> out_pad == core_out && bidi_pad_en == core_bidi_en);

endmodule

bind bscan_chain bscan_chain_chk #(.NI(NI), .NO(NO), .NB(NB)) u_chk (
  .tck          (tck),
  .trst_n       (trst_n),
  .sel          (sel),
  .extest       (extest),
  .tdo          (tdo),
  .core_out     (core_out),
  .core_bidi_en (core_bidi_en),
  .out_pad      (out_pad),
  .bidi_pad_en  (bidi_pad_en),
  .cap_fire     (cap_fire),
  .shift_fire   (shift_fire),
  .upd_fire     (upd_fire),
  .sr_q         (sr_q),
  .ur_q         (ur_q)
);

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int NI = 99;
  localparam int NO = 51;
  localparam int NB = 48;
  localparam int L  = NI + 2 * NO + 2 * NB;

  logic tck = 1'b0;
  always #4 tck = ~tck;  // 125 MHz

  logic trst_n = 1'b1, sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic extest = 1'b0, sample = 1'b0, tdi = 1'b0;
  logic [NI-1:0] in_pad = '0;
  logic [NO-1:0] core_out = '0, core_out_en = '0;
  logic [NB-1:0] core_bidi = '0, core_bidi_en = '0, bidi_pad_in = '0;
  logic tdo;
  logic [NO-1:0] out_pad, out_pad_en;
  logic [NB-1:0] bidi_pad_out, bidi_pad_en;

  bscan_chain #(.NI(NI), .NO(NO), .NB(NB)) u0 (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .extest(extest), .sample(sample), .tdi(tdi), .tdo(tdo),
    .in_pad(in_pad), .core_out(core_out), .core_out_en(core_out_en), .core_bidi(core_bidi),
    .core_bidi_en(core_bidi_en), .bidi_pad_in(bidi_pad_in), .out_pad(out_pad),
    .out_pad_en(out_pad_en), .bidi_pad_out(bidi_pad_out), .bidi_pad_en(bidi_pad_en)
  );

  // Reference model: serial stage as a queue (front = cell 0), hold stage as an array.
  bit msr[$];
  bit mur[L];
  int vectors = 0, miscompares = 0, cycles = 0;

  always @(posedge tck) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  function automatic bit x_out(int k);    return extest ? mur[NI+2*k]        : core_out[k];     endfunction
  function automatic bit x_out_en(int k); return extest ? mur[NI+2*k+1]      : core_out_en[k];  endfunction
  function automatic bit x_bd(int k);     return extest ? mur[NI+2*NO+2*k]   : core_bidi[k];    endfunction
  function automatic bit x_be(int k);     return extest ? mur[NI+2*NO+2*k+1] : core_bidi_en[k]; endfunction

  task automatic miss(string tag, string what, int idx, bit act, bit exp);
    miscompares++;
    $display("FAIL %s %s[%0d]: actual %0b expected %0b", tag, what, idx, act, exp);
  endtask

  task automatic compare(string tag);
    vectors++;
    if (tdo !== msr[0]) miss(tag, "tdo", 0, tdo, msr[0]);
    for (int k = 0; k < NO; k++) begin
      if (out_pad[k] !== x_out(k)) begin miss(tag, "out_pad", k, out_pad[k], x_out(k)); break; end
      if (out_pad_en[k] !== x_out_en(k)) begin miss(tag, "out_pad_en", k, out_pad_en[k], x_out_en(k)); break; end
    end
    for (int k = 0; k < NB; k++) begin
      if (bidi_pad_out[k] !== x_bd(k)) begin miss(tag, "bidi_pad_out", k, bidi_pad_out[k], x_bd(k)); break; end
      if (bidi_pad_en[k] !== x_be(k)) begin miss(tag, "bidi_pad_en", k, bidi_pad_en[k], x_be(k)); break; end
    end
  endtask

  // One clock: model next state from the inputs now applied, edge, then compare.
  task automatic tick(string tag);
    bit nsr[$];
    bit nur[L];
    nsr = msr;
    nur = mur;
    if (sel && capture_dr) begin
      if (extest) begin
        for (int i = 0; i < NI; i++) nsr[i] = in_pad[i];
        for (int k = 0; k < NB; k++) nsr[NI+2*NO+2*k] = bidi_pad_in[k];
      end else if (sample) begin
        for (int i = 0; i < NI; i++) nsr[i] = in_pad[i];
        for (int k = 0; k < NO; k++) begin
          nsr[NI+2*k]   = x_out(k);
          nsr[NI+2*k+1] = x_out_en(k);
        end
        for (int k = 0; k < NB; k++) begin
          nsr[NI+2*NO+2*k]   = x_be(k) ? x_bd(k) : bidi_pad_in[k];
          nsr[NI+2*NO+2*k+1] = x_be(k);
        end
      end
    end else if (sel && shift_dr) begin
      void'(nsr.pop_front());
      nsr.push_back(tdi);
    end
    if (sel && update_dr) for (int i = 0; i < L; i++) nur[i] = msr[i];
    @(posedge tck);
    msr = nsr;
    mur = nur;
    @(negedge tck);
    compare(tag);
  endtask

  task automatic rand_pins();
    for (int i = 0; i < NI; i++) in_pad[i] = 1'($urandom);
    for (int k = 0; k < NO; k++) begin core_out[k] = 1'($urandom); core_out_en[k] = 1'($urandom); end
    for (int k = 0; k < NB; k++) begin
      core_bidi[k] = 1'($urandom); core_bidi_en[k] = 1'($urandom); bidi_pad_in[k] = 1'($urandom);
    end
  endtask

  task automatic strobes(bit c, bit s, bit u);
    capture_dr = c; shift_dr = s; update_dr = u;
  endtask

  task automatic shift_run(string tag, int n);
    strobes(0, 1, 0);
    for (int i = 0; i < n; i++) begin
      tdi = 1'($urandom);
      tick(tag);
    end
    strobes(0, 0, 0);
  endtask

  initial begin
    msr.delete();
    for (int i = 0; i < L; i++) msr.push_back(1'b0);
    #1 trst_n = 1'b0;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    // R10: both stages clear; under extest every driven enable is 0.
    extest = 1'b1;
    rand_pins();
    tick("R10");
    // R9: core values pass through while extest is low.
    extest = 1'b0;
    rand_pins();
    tick("R9");
    rand_pins();
    tick("R9");
    // R3: sample capture, then shift the whole chain out (layout checked per R1).
    sel = 1'b1; sample = 1'b1;
    rand_pins();
    core_bidi_en = {NB/2{2'b10}};
    strobes(1, 0, 0);
    tick("R3");
    shift_run("R1", L);
    // R2 and R6: load fresh bits, update, then drive pads under extest (R7, R8).
    shift_run("R2", L);
    strobes(0, 0, 1);
    tick("R6");
    strobes(0, 0, 0);
    sample = 1'b0; extest = 1'b1;
    tick("R7");
    rand_pins();
    tick("R8");
    // R4: extest capture, with sample also high, output cells must keep their contents.
    sample = 1'b1;
    rand_pins();
    strobes(1, 0, 0);
    tick("R4");
    sample = 1'b0;
    shift_run("R4", L);
    // R5: unselected strobes and a flagless capture leave both stages alone.
    sel = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rand_pins();
      extest = 1'($urandom); sample = 1'($urandom);
      strobes(1'($urandom), 1'($urandom), 1'($urandom));
      tdi = 1'($urandom);
      tick("R5");
    end
    sel = 1'b1; extest = 1'b0; sample = 1'b0;
    strobes(1, 0, 0);
    tick("R5");
    extest = 1'b1;
    shift_run("R5", L);
    // Mixed random traffic, one strobe at a time.
    for (int i = 0; i < 3000; i++) begin
      int r;
      rand_pins();
      sel = ($urandom_range(0, 9) != 0);
      extest = 1'($urandom); sample = 1'($urandom);
      r = $urandom_range(0, 9);
      strobes(r == 0, r >= 1 && r <= 7, r == 8);
      tdi = 1'($urandom);
      tick("R2 R3 R4 R6 R7 R8");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule